// File: doc/BRIEF.md
# Dual-Compare Timer with Preload

The block is a peripheral timer. A 10-bit up-counter runs continuously and steps once for every enable pulse of the clock source that is selected: a half-rate tick, a slower tick at one eighth of that rate, or the output of another timer. Two compare channels watch the counter. A channel fires when the counter moves onto the channel's active compare value. It does not fire again while the counter holds that value. The match is a one-clock strobe that external output latches can use, and it can also raise an interrupt.

Software never writes the active compare registers. It writes a per-channel preload pair over a byte-wide register bus, high part first and low part last. When a channel matches, its preload value moves into its active compare register, so each match arms the next one. A match also drops the channel's armed state, and software must write the low byte again before that channel can flag another interrupt. The high byte stays as it was. Reading the status register clears the pending flags. A low-then-high pair of count reads returns the two halves of one counter value.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count is 0, both active compare and preload values are 0, both channels are unarmed, both status flags and the global enable are 0, the control register is 0, and irq and both strobes are low.
- R2: Control bits 1:0 at offset 0x1 select the count source: 0 = tick_div2, 1 = tick_div16, 2 = tick_ext, 3 = stopped. The count goes up by exactly one on each clock where the selected enable is high, ignores the other enables, and wraps from 1023 to 0.
- R3: A channel matches only in the clock after the count has changed to a value equal to its active compare value. A count that rests on that value gives no further match.
- R4: Each match drives that channel's match_strobe bit high for exactly one clock (bit 0 = channel 1, bit 1 = channel 2).
- R5: On a match the channel's active compare value loads from its preload {high[1:0], low[7:0]}. Channel 1 high/low sit at offsets 0x2/0x3 and channel 2 high/low at 0x4/0x5. Only bits 1:0 of a high write are kept.
- R6: A low-byte write arms the channel, and a match disarms it. A match on an armed channel sets its status flag (status bit 1 = channel 1, bit 2 = channel 2). A match on an unarmed channel sets no flag but still strobes.
- R7: A read at offset 0x0 returns {5'b0, flag2, flag1, global enable} and clears both flags. A match in the same clock keeps its flag set.
- R8: Writing offset 0x0 sets the global enable from data bit 0. irq is high when the global enable is set and some flag is set whose enable bit is set (control bit 2 for channel 1, control bit 3 for channel 2).
- R9: A read at offset 0xF returns count bits 7:0 and captures count bits 9:8. A read at 0xE returns the captured bits in bits 1:0, with bits 7:2 zero.
- R10: Reads of the write-only offsets (0x1 to 0x5) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div2 | input | 1 | Count enable, half-rate source |
| tick_div16 | input | 1 | Count enable, slow source |
| tick_ext | input | 1 | Count enable from another timer |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Interrupt request |
| match_strobe | output | 2 | One-clock match pulse per channel |

## Verification
The bench builds the block with its defaults: a 10-bit counter and two channels. A full wrap takes about a thousand ticks, so the bench drives the count through 1023 to 0 and sees both channels match on the reset compare value of zero. The counts in the vector table are small, so every source setting is tried without reaching a compare value by accident. Later runs place the count on exact compare values, which covers the armed and unarmed cases, the resting count, and a channel whose interrupt enable is off.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam logic [3:0] ADDR_STAT   = 4'h0;
  localparam logic [3:0] ADDR_CTRL   = 4'h1;
  localparam logic [3:0] ADDR_CH0    = 4'h2;
  localparam logic [3:0] ADDR_CNT_HI = 4'hE;
  localparam logic [3:0] ADDR_CNT_LO = 4'hF;

  typedef enum logic [1:0] {
    SRC_DIV2  = 2'd0,
    SRC_DIV16 = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_OFF   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_div2,
  input  logic                  tick_div16,
  input  logic                  tick_ext,
  input  dct_pkg::src_sel_e     sel,
  output logic [CNT_W-1:0]      count,
  output logic                  changed
);
  import dct_pkg::*;

  logic             step;
  logic [CNT_W-1:0] count_n;

  always_comb begin
    case (sel)
      SRC_DIV2:  step = tick_div2;
      SRC_DIV16: step = tick_div16;
      SRC_EXT:   step = tick_ext;
      default:   step = 1'b0;
    endcase
    count_n = step ? count + CNT_W'(1) : count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      changed <= 1'b0;
    end else begin
      count   <= count_n;
      changed <= step;
    end
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             changed,
  input  logic [CNT_W-1:0] preload,
  output logic             match,
  output logic [CNT_W-1:0] cmp
);
  logic [CNT_W-1:0] cmp_n;

  always_comb begin
    match = changed && (count == cmp);
    cmp_n = match ? preload : cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp <= '0;
    else        cmp <= cmp_n;
  end
endmodule

// File: rtl/dct_regs.sv
module dct_regs #(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DW-1:0]                bus_wdata,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  output logic [DW-1:0]                bus_rdata,
  input  logic [CNT_W-1:0]             count,
  input  logic [NUM_CH-1:0]            match,
  output dct_pkg::src_sel_e            sel,
  output logic [NUM_CH-1:0][CNT_W-1:0] preload,
  output logic [NUM_CH-1:0]            valid,
  output logic [NUM_CH-1:0]            flag,
  output logic                         gie,
  output logic                         irq
);
  import dct_pkg::*;

  localparam int HI_W   = CNT_W - DW;
  localparam int CTRL_W = 2 + NUM_CH;

  logic [CTRL_W-1:0]            ctrl, ctrl_n;
  logic                         gie_n;
  logic [NUM_CH-1:0]            flag_n, valid_n, ie;
  logic [NUM_CH-1:0][HI_W-1:0]  pre_hi, pre_hi_n;
  logic [NUM_CH-1:0][DW-1:0]    pre_lo, pre_lo_n;
  logic [HI_W-1:0]              hold, hold_n;
  logic                         wr_stat, wr_ctrl, rd_stat, rd_lo;

  always_comb begin
    wr_stat = bus_wr && (bus_addr == AW'(ADDR_STAT));
    wr_ctrl = bus_wr && (bus_addr == AW'(ADDR_CTRL));
    rd_stat = bus_rd && (bus_addr == AW'(ADDR_STAT));
    rd_lo   = bus_rd && (bus_addr == AW'(ADDR_CNT_LO));
    sel     = src_sel_e'(ctrl[1:0]);
    ie      = ctrl[2 +: NUM_CH];
    irq     = gie && |(flag & ie);
  end

  always_comb begin
    ctrl_n   = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl;
    gie_n    = wr_stat ? bus_wdata[0] : gie;
    hold_n   = rd_lo ? count[CNT_W-1:DW] : hold;
    pre_hi_n = pre_hi;
    pre_lo_n = pre_lo;
    for (int k = 0; k < NUM_CH; k++) begin
      flag_n[k]  = flag[k];
      valid_n[k] = valid[k];
      if (rd_stat)             flag_n[k]  = 1'b0;
      if (match[k] && valid[k]) flag_n[k] = 1'b1;
      if (match[k])            valid_n[k] = 1'b0;
      if (bus_wr && (bus_addr == AW'(ADDR_CH0) + AW'(2*k)))
        pre_hi_n[k] = bus_wdata[HI_W-1:0];
      if (bus_wr && (bus_addr == AW'(ADDR_CH0) + AW'(2*k+1))) begin
        pre_lo_n[k] = bus_wdata;
        valid_n[k]  = 1'b1;
      end
      preload[k] = {pre_hi[k], pre_lo[k]};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_STAT)) begin
      bus_rdata[0]        = gie;
      bus_rdata[NUM_CH:1] = flag;
    end else if (bus_addr == AW'(ADDR_CNT_LO)) begin
      bus_rdata = count[DW-1:0];
    end else if (bus_addr == AW'(ADDR_CNT_HI)) begin
      bus_rdata[HI_W-1:0] = hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      gie    <= 1'b0;
      flag   <= '0;
      valid  <= '0;
      pre_hi <= '0;
      pre_lo <= '0;
      hold   <= '0;
    end else begin
      ctrl   <= ctrl_n;
      gie    <= gie_n;
      flag   <= flag_n;
      valid  <= valid_n;
      pre_hi <= pre_hi_n;
      pre_lo <= pre_lo_n;
      hold   <= hold_n;
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_div2,
  input  logic              tick_div16,
  input  logic              tick_ext,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic [NUM_CH-1:0] match_strobe
);
  import dct_pkg::*;

  src_sel_e                     sel;
  logic [CNT_W-1:0]             cnt;
  logic                         cnt_chg;
  logic [NUM_CH-1:0]            match;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
  logic [NUM_CH-1:0][CNT_W-1:0] preload;
  logic [NUM_CH-1:0]            valid, flag;
  logic                         gie;

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tick_div2(tick_div2), .tick_div16(tick_div16), .tick_ext(tick_ext),
    .sel(sel), .count(cnt), .changed(cnt_chg)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .count(cnt), .changed(cnt_chg),
      .preload(preload[k]), .match(match[k]), .cmp(cmp_act[k])
    );
  end

  dct_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .count(cnt), .match(match), .sel(sel),
    .preload(preload), .valid(valid), .flag(flag), .gie(gie), .irq(irq)
  );

  assign match_strobe = match;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2,
  parameter int AW     = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [AW-1:0]                bus_addr,
  input logic                         bus_wr,
  input logic                         bus_rd,
  input logic                         irq,
  input logic [NUM_CH-1:0]            match_strobe,
  input logic [CNT_W-1:0]             cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
  input logic [NUM_CH-1:0][CNT_W-1:0] preload,
  input logic [NUM_CH-1:0]            valid,
  input logic [NUM_CH-1:0]            flag,
  input logic                         gie
);
  // R2: the count only ever advances by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CNT_W'(1)));

  // R8: no interrupt without the global enable
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);

  // R7: a status read with no match in that clock leaves no flags
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(0) && match_strobe == '0) |=> (flag == '0));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    // R3: a match follows a change of the count
    p_match_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      match_strobe[k] |-> (cnt != $past(cnt)));

    // R5: the active compare loads the preload on a match
    p_cmp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_strobe[k] |=> (cmp_act[k] == $past(preload[k])));

    // R6: a match disarms the channel unless the low byte is written in the same clock
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (match_strobe[k] && !(bus_wr && bus_addr == AW'(3 + 2*k))) |=> !valid[k]);
  end
endmodule

bind dual_cmp_timer dct_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .irq(irq), .match_strobe(match_strobe), .cnt(cnt), .cmp_act(cmp_act),
  .preload(preload), .valid(valid), .flag(flag), .gie(gie)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
  logic       clk;
  logic       rst_n;
  logic       tick_div2, tick_div16, tick_ext;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [1:0] match_strobe;

  int checks = 0;
  int errors = 0;
  int stb1 = 0;
  int stb2 = 0;
  int exp_cnt = 0;
  bit done = 0;

  dual_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_div2(tick_div2), .tick_div16(tick_div16),
    .tick_ext(tick_ext), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
    .match_strobe(match_strobe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (match_strobe[0]) stb1++;
    if (match_strobe[1]) stb2++;
  end

  // {sel, src pulsed (0 div2, 1 div16, 2 ext), pulses, counts}
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 2'd0, 4'd3, 1'b1},
    {2'd0, 2'd1, 4'd4, 1'b0},
    {2'd1, 2'd1, 4'd2, 1'b1},
    {2'd1, 2'd0, 4'd5, 1'b0},
    {2'd2, 2'd2, 4'd6, 1'b1},
    {2'd2, 2'd1, 4'd3, 1'b0},
    {2'd3, 2'd0, 4'd4, 1'b0},
    {2'd3, 2'd2, 4'd2, 1'b0}
  };

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_div2  = (src == 0);
      tick_div16 = (src == 1);
      tick_ext   = (src == 2);
      @(negedge clk);
      tick_div2 = 1'b0; tick_div16 = 1'b0; tick_ext = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_count(input string req, input int expv);
    int lo, hi;
    rd(4'hF, lo);
    rd(4'hE, hi);
    check(req, hi * 256 + lo, expv % 1024);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    rst_n = 1'b0;
    tick_div2 = 0; tick_div16 = 0; tick_ext = 0;
    bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 strobe", int'(match_strobe), 0);
    rd(4'h0, d); check("R1 status", d, 0);
    check_count("R1 R9 count", 0);
    rd(4'h1, d); check("R10 ctrl read", d, 0);

    wr(4'h1, 8'h0C);
    wr(4'h0, 8'h01);
    rd(4'h0, d); check("R8 gie set", d, 1);

    // R2: source selection table
    for (int v = 0; v < 8; v++) begin
      wr(4'h1, {6'b000011, VEC[v][8:7]} | 8'h0C);
      pulse(int'(VEC[v][6:5]), int'(VEC[v][4:1]));
      if (VEC[v][0]) exp_cnt += int'(VEC[v][4:1]);
      check_count($sformatf("R2 vector %0d", v), exp_cnt);
    end
    check("R3 no strobe in table", stb1 + stb2, 0);

    // Preloads: ch1 = 5, ch2 = 272
    wr(4'h1, 8'h0C);
    wr(4'h2, 8'h00); wr(4'h3, 8'h05);
    wr(4'h4, 8'hFD); wr(4'h5, 8'h10);
    rd(4'h2, d); check("R10 preload read", d, 0);
    pulse(0, 1024 - exp_cnt);
    exp_cnt = 0;
    idle(2);
    check("R2 R4 wrap strobe ch1", stb1, 1);
    check("R4 wrap strobe ch2", stb2, 1);
    check("R8 irq after wrap", int'(irq), 1);
    rd(4'h0, d); check("R6 R7 status after wrap", d, 7);
    check("R7 irq cleared", int'(irq), 0);
    rd(4'h0, d); check("R7 flags cleared", d, 1);

    // Re-arm ch1 with a new preload before reaching 5
    wr(4'h3, 8'h09);
    pulse(0, 5); exp_cnt = 5; idle(2);
    check("R5 ch1 match at 5", stb1, 2);
    check("R8 irq ch1", int'(irq), 1);
    rd(4'h0, d); check("R6 armed match flag", d, 3);
    pulse(0, 4); exp_cnt = 9; idle(2);
    check("R5 ch1 match at 9", stb1, 3);
    rd(4'h0, d); check("R6 unarmed match no flag", d, 1);
    check("R6 irq unarmed", int'(irq), 0);

    // R3: resting on the compare value
    wr(4'h1, 8'h07);
    idle(10);
    check("R3 no repeat while stopped", stb1, 3);
    check_count("R9 count stopped", 9);

    // ch2: re-arm, interrupt enable off; high byte kept at 1
    wr(4'h5, 8'h10);
    wr(4'h1, 8'h04);
    pulse(0, 272 - 9); exp_cnt = 272; idle(2);
    check("R5 ch2 match at 272", stb2, 2);
    check("R8 irq masked", int'(irq), 0);
    rd(4'h0, d); check("R6 ch2 flag", d, 5);
    check_count("R9 count 272", 272);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule